// File: doc/BRIEF.md
# Programmable Output Clock Divider

This block takes the free-running VCO clock of a frequency synthesizer and produces a divided clock, which it sends to six identical true/complement output pairs. A 3-bit ratio code picks the divisor from {1, 2, 4, 8, 16}. Every divisor gives a 50% duty cycle. For divide-by-1 the VCO clock itself is routed to the outputs.

Two controls gate the outputs. The output enable is re-timed so that a change reaches the pins only after one VCO rising edge and then one VCO falling edge. This keeps enable changes from cutting a VCO pulse short. The master reset clears the divider and forces every true output low and every complement output high.

A new ratio code takes effect only when a new output period starts, which is the rising edge of the divided clock. A phase that is already under way always runs to its full length.

Top module: `ckdiv_out`

## Requirements
- R1: The output period, in VCO cycles, follows the ratio code: 000 gives 2, 001 gives 4, 010 gives 8, 011 gives 16, 100 gives 1, 101 gives 2, 110 gives 4 and 111 gives 8.
- R2: For every divisor D of 2 or more, the high phase and the low phase of the output each last exactly D/2 VCO cycles. For code 100 the output follows the VCO clock, high while it is high and low while it is low.
- R3: While the re-timed enable is off, every true output is low and every complement output is high, whatever the ratio code.
- R4: A change of the output enable reaches the outputs at the first VCO falling edge that follows the first VCO rising edge after the change. Before that edge the outputs keep their previous enable state.
- R5: While master reset is high, the true outputs are low and the complement outputs are high. After master reset falls, the first VCO rising edge starts a new high phase at the current ratio code.
- R6: All six true outputs carry the same value at all times, and so do all six complement outputs.
- R7: A ratio code change is applied only at the next rising edge of the divided clock. The phase in progress keeps its old length, and no phase is shorter than the smaller of the old and new half-periods.
- R8: Each complement output is always the exact inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock; the source that is divided |
| mr | input | 1 | Master reset, active high, sampled on the VCO rising edge; it also gates the outputs directly |
| n_code | input | 3 | Ratio code that selects the divisor |
| oe | input | 1 | Output enable, active high |
| fout | output | NUM_PAIRS (6) | True divided clock outputs |
| fout_n | output | NUM_PAIRS (6) | Complement divided clock outputs |

## Verification
The bench samples the outputs once in the middle of each VCO half-cycle. A phase length is therefore counted in half-cycles and compared with the divisor that the bench derives from the code.

The timed checks are due at these points:
- An enable change set 5 ns after a VCO rising edge is still absent in the high half of the next cycle. It shows in the high half of the cycle after that.
- Master reset masks the outputs within the same half-cycle.
- After reset release, the first high phase is visible from the falling edge of the first cycle. It falls exactly D/2 cycles after that cycle's rising edge.
- A code change made just after a rising output edge leaves the old high and low phases intact. The new divisor's first high phase starts at the rising edge that ends the old period.

A running monitor counts every completed phase across code changes. It flags any phase shorter than the smaller half-period.

// File: rtl/ckdiv_out_pkg.sv
package ckdiv_out_pkg;

    localparam int CODE_W  = 3;
    localparam int MAX_DIV = 16;
    localparam int HALF_W  = $clog2(MAX_DIV / 2) + 1;

    typedef logic [CODE_W-1:0] ncode_t;
    typedef logic [HALF_W-1:0] half_t;

    // Active divider setting: bypass routes the VCO clock straight through,
    // otherwise each phase lasts 'half' VCO cycles.
    typedef struct packed {
        logic  bypass;
        half_t half;
    } ratio_t;

    localparam ncode_t BYPASS_CODE = 3'b100;
    localparam ncode_t RESET_CODE  = 3'b000;

    // Upper bit clear: divisor 2 << low bits. Upper bit set: divisor 1 << low bits.
    function automatic ratio_t decode_ratio(ncode_t c);
        ratio_t     r;
        logic [1:0] sh;
        sh       = c[2] ? (c[1:0] - 2'd1) : c[1:0];
        r.bypass = (c == BYPASS_CODE);
        r.half   = r.bypass ? half_t'(1) : (half_t'(1) << sh);
        return r;
    endfunction

endpackage

// File: rtl/ckdiv_core.sv
module ckdiv_core
    import ckdiv_out_pkg::*;
(
    input  logic   vco_clk,
    input  logic   mr,
    input  ncode_t code_i,
    output logic   src_o
);

    ratio_t act;
    ratio_t nxt;
    half_t  cnt;
    logic   div_q;
    logic   wrap;
    logic   period_start;

    assign nxt          = decode_ratio(code_i);
    assign wrap         = (cnt == act.half - half_t'(1));
    // A new period begins where the low phase ends; in bypass every edge qualifies.
    assign period_start = act.bypass || (wrap && !div_q);

    always_ff @(posedge vco_clk) begin
        if (mr) begin
            act   <= decode_ratio(RESET_CODE);
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (period_start) begin
            act   <= nxt;
            cnt   <= '0;
            div_q <= 1'b1;
        end else if (wrap) begin
            cnt   <= '0;
            div_q <= ~div_q;
        end else begin
            cnt   <= cnt + half_t'(1);
        end
    end

    assign src_o = act.bypass ? vco_clk : div_q;

endmodule

// File: rtl/ckdiv_oe_sync.sv
module ckdiv_oe_sync (
    input  logic vco_clk,
    input  logic mr,
    input  logic oe_i,
    output logic en_o
);

    logic en_rise;
    logic en_fall;

    always_ff @(posedge vco_clk) begin
        if (mr) en_rise <= 1'b0;
        else    en_rise <= oe_i;
    end

    // The second stage moves on the falling edge, where a passed-through VCO
    // clock is low and the divided clock is steady.
    always_ff @(negedge vco_clk) begin
        if (mr) en_fall <= 1'b0;
        else    en_fall <= en_rise;
    end

    assign en_o = en_fall;

endmodule

// File: rtl/ckdiv_fanout.sv
module ckdiv_fanout #(
    parameter int NUM_PAIRS = 6
) (
    input  logic                 src_i,
    input  logic                 en_i,
    input  logic                 mr,
    output logic [NUM_PAIRS-1:0] fout,
    output logic [NUM_PAIRS-1:0] fout_n
);

    logic gated;

    assign gated = src_i & en_i & ~mr;

    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        assign fout[i]   = gated;
        assign fout_n[i] = ~gated;
    end

endmodule

// File: rtl/ckdiv_out.sv
module ckdiv_out
    import ckdiv_out_pkg::*;
#(
    parameter int NUM_PAIRS = 6
) (
    input  logic                 vco_clk,
    input  logic                 mr,
    input  logic [CODE_W-1:0]    n_code,
    input  logic                 oe,
    output logic [NUM_PAIRS-1:0] fout,
    output logic [NUM_PAIRS-1:0] fout_n
);

    logic src;
    logic en;

    ckdiv_core u_core (
        .vco_clk (vco_clk),
        .mr      (mr),
        .code_i  (n_code),
        .src_o   (src)
    );

    ckdiv_oe_sync u_oe (
        .vco_clk (vco_clk),
        .mr      (mr),
        .oe_i    (oe),
        .en_o    (en)
    );

    ckdiv_fanout #(.NUM_PAIRS(NUM_PAIRS)) u_fan (
        .src_i   (src),
        .en_i    (en),
        .mr      (mr),
        .fout    (fout),
        .fout_n  (fout_n)
    );

endmodule

// File: rtl/ckdiv_out_chk.sv
module ckdiv_out_chk #(
    parameter int NUM_PAIRS = 6
) (
    input logic                 vco_clk,
    input logic                 mr,
    input logic [2:0]           n_code,
    input logic                 oe,
    input logic [NUM_PAIRS-1:0] fout,
    input logic [NUM_PAIRS-1:0] fout_n
);

    // R8: complement pins mirror the true pins
    p_comp_inverse_r8: assert property (@(posedge vco_clk) disable iff (mr)
        fout_n == ~fout);

    // R6: all pairs carry the same clock
    p_pairs_equal_r6: assert property (@(posedge vco_clk) disable iff (mr)
        (fout == '0) || (fout == '1));

    // R3: an enable seen low at one rising edge blanks the outputs by the next
    p_oe_blank_r3: assert property (@(posedge vco_clk) disable iff (mr)
        !oe |=> (fout == '0));

    // R4: at the edge where a raised enable is first sampled, outputs are still off
    p_oe_late_r4: assert property (@(posedge vco_clk) disable iff (mr)
        $rose(oe) |-> (fout == '0));

    // R5: reset holds true pins low and complement pins high
    always @(posedge vco_clk) begin
        if (mr === 1'b1) begin
            p_mr_quiet_r5: assert ((fout == '0) && (fout_n == '1));
        end
    end

endmodule

bind ckdiv_out ckdiv_out_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .vco_clk (vco_clk),
    .mr      (mr),
    .n_code  (n_code),
    .oe      (oe),
    .fout    (fout),
    .fout_n  (fout_n)
);

// File: tb/sim_ckdiv_out.sv
module sim_ckdiv_out;

    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          mr;
    logic [2:0]    n_code;
    logic          oe;
    logic [NP-1:0] fout;
    logic [NP-1:0] fout_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // sampler state
    bit rec_on  = 0;
    int rec_n   = 0;
    bit rec_buf [0:199];
    int pair_bad = 0;
    bit mon_on  = 0;
    int mon_min = 1;
    int mon_bad = 0;
    int run_len = 0;
    bit run_valid = 0;
    bit prev_s = 0;

    always #10 clk = ~clk;

    ckdiv_out #(.NUM_PAIRS(NP)) u0 (
        .vco_clk (clk),
        .mr      (mr),
        .n_code  (n_code),
        .oe      (oe),
        .fout    (fout),
        .fout_n  (fout_n)
    );

    function automatic int exp_div(input logic [2:0] c);
        // R1 ratio map: upper bit clear doubles, upper bit set does not
        if (c[2]) return 1 << c[1:0];
        else      return 2 << c[1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic take();
        bit s;
        s = fout[0];
        if (rec_on) begin
            if ((fout != '0) && (fout != '1)) pair_bad++;
            if (fout_n != ~fout) pair_bad++;
            if (rec_n < 200) rec_buf[rec_n] = s;
            rec_n++;
        end
        if (mon_on) begin
            if (s == prev_s) run_len++;
            else begin
                if (run_valid && run_len < mon_min) mon_bad++;
                run_valid = 1;
                run_len = 1;
            end
        end
        prev_s = s;
    endtask

    // one sample in the middle of every VCO half-cycle
    initial begin
        forever begin
            @(posedge clk); #5; take();
            @(negedge clk); #5; take();
        end
    end

    task automatic sweep_code(input logic [2:0] c);
        int d, first_hi, first_lo, bad, last_t, runs;
        d = exp_div(c);
        @(posedge clk); #2; n_code = c;
        repeat (40) @(posedge clk);
        #2; rec_n = 0; pair_bad = 0; rec_on = 1;
        repeat (3 * d + 4) @(posedge clk);
        #2; rec_on = 0;
        first_hi = -1; first_lo = -1; bad = 0; last_t = -1; runs = 0;
        for (int i = 1; i < rec_n && i < 200; i++) begin
            if (rec_buf[i] != rec_buf[i-1]) begin
                if (last_t >= 0) begin
                    runs++;
                    if (i - last_t != d) bad++;
                    if (rec_buf[i-1] && first_hi < 0) first_hi = i - last_t;
                    if (!rec_buf[i-1] && first_lo < 0) first_lo = i - last_t;
                end
                last_t = i;
            end
        end
        // phase lengths are in half-cycles: a period of D cycles is 2D halves
        chk(runs >= 2 && (first_hi + first_lo) == 2 * d, "R1",
            $sformatf("period for code %0b (half-cycles)", c), first_hi + first_lo, 2 * d);
        chk(bad == 0 && first_hi == first_lo, "R2",
            $sformatf("duty for code %0b (high halves)", c), first_hi, d);
        chk(pair_bad == 0, "R6/R8",
            $sformatf("pair equality and complement for code %0b", c), pair_bad, 0);
    endtask

    initial begin
        bit last;
        int viol;
        mr = 1'b1; oe = 1'b1; n_code = 3'b011;
        repeat (5) @(posedge clk);
        #5;
        chk(fout == '0, "R5", "true outputs in reset", int'(fout), 0);
        chk(fout_n == '1, "R5", "complement outputs in reset", int'(fout_n), 63);

        // release: first rising edge starts a 16-divide high phase (8 cycles)
        @(posedge clk); #2; mr = 1'b0;
        @(posedge clk); #15;
        chk(fout[0] == 1'b1, "R5", "high after first edge past release", fout[0], 1);
        repeat (7) @(posedge clk); #15;
        chk(fout[0] == 1'b1, "R5", "still high in cycle 8", fout[0], 1);
        @(posedge clk); #5;
        chk(fout[0] == 1'b0, "R5", "low after 8 cycles", fout[0], 0);
        repeat (8) @(posedge clk); #5;
        chk(fout[0] == 1'b1, "R5", "next period rises after 8 low cycles", fout[0], 1);

        // R1, R2, R6, R8 over every code
        for (int c = 0; c < 8; c++) sweep_code(3'(c));

        // R5: reset mid-run masks a passed-through VCO high phase
        @(posedge clk); #2; n_code = 3'b100;
        repeat (10) @(posedge clk);
        #2; mr = 1'b1; #3;
        chk(fout == '0 && fout_n == '1, "R5", "reset masks output in high VCO phase",
            int'(fout), 0);
        @(posedge clk); #2; mr = 1'b0;
        repeat (10) @(posedge clk);

        // R4: disable timing with divide-by-1
        @(posedge clk); #5; oe = 1'b0;
        @(posedge clk); #5;
        chk(fout == '1, "R4", "still enabled one edge after disable", int'(fout), 63);
        @(posedge clk); #5;
        chk(fout == '0, "R4", "disabled after rising then falling edge", int'(fout), 0);

        // R3: held off across codes and both VCO phases
        viol = 0;
        for (int c = 0; c < 8; c++) begin
            @(posedge clk); #2; n_code = 3'(c);
            repeat (20) begin
                @(posedge clk); #5;
                if (fout != '0 || fout_n != '1) viol++;
                @(negedge clk); #5;
                if (fout != '0 || fout_n != '1) viol++;
            end
        end
        chk(viol == 0, "R3", "outputs held off while disabled", viol, 0);

        @(posedge clk); #2; n_code = 3'b100;
        repeat (40) @(posedge clk);
        #5; oe = 1'b1;
        @(posedge clk); #5;
        chk(fout == '0, "R4", "still disabled one edge after enable", int'(fout), 0);
        @(posedge clk); #5;
        chk(fout == '1, "R4", "enabled after rising then falling edge", int'(fout), 63);

        // R7: code change lands only at the next rising output edge
        @(posedge clk); #2; n_code = 3'b011;
        repeat (40) @(posedge clk);
        #2; mon_min = 4; run_valid = 0; run_len = 0; mon_bad = 0; mon_on = 1;
        last = fout[0];
        forever begin
            @(posedge clk); #5;
            if (fout[0] && !last) break;
            last = fout[0];
        end
        n_code = 3'b001;
        repeat (7) @(posedge clk); #15;
        chk(fout[0] == 1'b1, "R7", "old high phase kept after code change", fout[0], 1);
        @(posedge clk); #5;
        chk(fout[0] == 1'b0, "R7", "old high phase ends at 8 cycles", fout[0], 0);
        repeat (8) @(posedge clk); #5;
        chk(fout[0] == 1'b1, "R7", "new period starts after full old low phase", fout[0], 1);
        repeat (2) @(posedge clk); #5;
        chk(fout[0] == 1'b0, "R7", "new high phase is 2 cycles", fout[0], 0);
        repeat (2) @(posedge clk); #5;
        chk(fout[0] == 1'b1, "R7", "new low phase is 2 cycles", fout[0], 1);
        repeat (3) @(posedge clk); #12; n_code = 3'b010;
        repeat (40) @(posedge clk);
        #7; n_code = 3'b110;
        repeat (40) @(posedge clk);
        #2; mon_on = 0;
        chk(mon_bad == 0, "R7", "phases shorter than smaller half-period", mon_bad, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule